// File: doc/BRIEF.md
# Byte-Stream Instruction Subset Decoder

This block sits behind an instruction fetch path and turns a stream of instruction bytes, delivered one per clock with a valid strobe, into decoded records. It covers two forms of a variable-length encoding. The first is a register-to-register add, carried in two bytes: an opcode byte, then an operand byte. The second is a move of an immediate into a register: an opcode byte followed by the immediate. Either form may be preceded by an operand-size prefix byte that widens the operation to 32 bits.

Each complete instruction yields one record and a one-cycle completion strobe. The record holds the operation, the destination register, the source register or the immediate, and the operand size. Immediates arrive lowest byte first and are reassembled into one word. Any byte pattern outside the subset raises a one-cycle illegal strobe. The decoder then drops any pending prefix and waits for a fresh opcode.

Top module: `isa_subset_decoder`

## Requirements
- R1: After a synchronous active-low reset, dec_done and dec_illegal are 0, and dec_op, dec_dst, dec_src, dec_size and dec_imm are all 0.
- R2: An opcode byte 0x00 to 0x03 starts an add. The following byte carries a mode in bits 7:6, a reg field in bits 5:3 and an rm field in bits 2:0. Mode 11 completes the add with dec_op = 1 and dec_imm = 0.
- R3: Opcode bit 1 is the direction bit. When it is 1, reg is the destination and rm is the source. When it is 0, rm is the destination and reg is the source. For example, 0x03 0xC3 gives destination 0 and source 3.
- R4: Opcode bit 0 is the width bit. A value of 0 gives dec_size = 0 (8 bits). A value of 1 gives dec_size = 1 (16 bits), or dec_size = 2 (32 bits) when the instruction carries a prefix.
- R5: An opcode byte 0xB8 to 0xBF is a move-immediate with dec_op = 2, destination equal to opcode bits 2:0 and dec_src = 0. It takes 2 immediate bytes with dec_size = 1, or 4 bytes with dec_size = 2 under a prefix.
- R6: Immediate bytes are placed lowest byte first. The sequence 0x66 0xB8 0x78 0x56 0x34 0x12 yields dec_imm = 0x12345678. A 16-bit immediate has its upper 16 bits at zero.
- R7: The prefix byte 0x66 raises no strobe and applies only to the next instruction. It is cleared once that instruction completes or is rejected. Repeated prefixes act as one.
- R8: dec_done is high for exactly the one cycle after the final byte of an instruction is accepted, and at no other time. The record holds its value until the next completion.
- R9: An add whose operand byte has a mode other than 11 pulses dec_illegal in the cycle after that byte. It leaves the record unchanged, clears the prefix and returns to opcode wait.
- R10: Any opcode byte other than 0x66, 0x00 to 0x03 and 0xB8 to 0xBF pulses dec_illegal in the next cycle and clears the prefix. dec_done and dec_illegal are never high together.
- R11: Cycles with in_valid low advance nothing: no strobe follows them, and the record holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_byte holds an instruction byte this cycle |
| in_byte | input | 8 | Instruction byte |
| dec_done | output | 1 | One-cycle strobe: a record was completed |
| dec_illegal | output | 1 | One-cycle strobe: a byte sequence was rejected |
| dec_op | output | 2 | Operation: 0 none, 1 add, 2 move-immediate |
| dec_dst | output | 3 | Destination register code |
| dec_src | output | 3 | Source register code (0 for move-immediate) |
| dec_size | output | 2 | Operand size: 0 = 8, 1 = 16, 2 = 32 bits |
| dec_imm | output | 32 | Assembled immediate (0 for add) |

## Verification
The bench builds the decoder with its default parameters: 8-bit bytes and a 4-byte immediate store. With these values both immediate lengths are reachable, 2 bytes without a prefix and 4 with one, so the lane filling and the zero upper half of short immediates are both exercised. Random instruction streams mix prefixed and plain forms, bad operand modes, stray opcodes and idle gaps between bytes. Directed cases pin down the worked encodings and a prefix that is dropped by a rejected opcode.

// File: rtl/isad_pkg.sv
// Shared encodings for the instruction subset decoder.
// Assumes byte-wide instruction units; opcode patterns are fixed 8-bit values.
package isad_pkg;

    typedef enum logic [1:0] {
        CLS_PFX  = 2'd0,
        CLS_ADD  = 2'd1,
        CLS_MOVI = 2'd2,
        CLS_BAD  = 2'd3
    } byte_class_e;

    typedef enum logic [1:0] {
        ST_OPC   = 2'd0,
        ST_MODRM = 2'd1,
        ST_IMM   = 2'd2
    } dec_state_e;

    localparam logic [1:0] OP_NONE = 2'd0;
    localparam logic [1:0] OP_ADD  = 2'd1;
    localparam logic [1:0] OP_MOVI = 2'd2;

    localparam logic [1:0] SZ_8  = 2'd0;
    localparam logic [1:0] SZ_16 = 2'd1;
    localparam logic [1:0] SZ_32 = 2'd2;

    localparam logic [7:0] PFX_SIZE  = 8'h66;
    localparam logic [5:0] ADD_TOP6  = 6'b000000;
    localparam logic [4:0] MOVI_TOP5 = 5'b10111;
    localparam logic [1:0] MODE_REG  = 2'b11;

endpackage

// File: rtl/isad_classify.sv
// Opcode classifier: sorts a byte seen in opcode position into prefix, add,
// move-immediate or unknown. Purely combinational; assumes BYTE_W is 8.
module isad_classify
    import isad_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] opc,
    output byte_class_e       cls
);

    // Match the byte against the known opcode patterns.
    always_comb begin
        if (opc == PFX_SIZE)
            cls = CLS_PFX;
        else if (opc[7:2] == ADD_TOP6)
            cls = CLS_ADD;
        else if (opc[7:3] == MOVI_TOP5)
            cls = CLS_MOVI;
        else
            cls = CLS_BAD;
    end

endmodule

// File: rtl/isad_imm_gather.sv
// Immediate collector: one register per byte lane, filled lowest lane first.
// merged shows the held lanes with the incoming byte already placed, so the
// final byte can be captured into the record in the same cycle it arrives.
// Assumes clear and load are never high together.
module isad_imm_gather #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    localparam int LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int IMM_W  = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] din,
    output logic [IMM_W-1:0]  merged
);

    logic [IMM_W-1:0] held;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Hold one immediate byte; zeroed when a new opcode starts.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[g*BYTE_W +: BYTE_W] <= '0;
            else if (clear)
                held[g*BYTE_W +: BYTE_W] <= '0;
            else if (load && (lane == LANE_W'(g)))
                held[g*BYTE_W +: BYTE_W] <= din;
        end

        // Present this lane with the arriving byte substituted.
        assign merged[g*BYTE_W +: BYTE_W] =
            (load && (lane == LANE_W'(g))) ? din : held[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/isa_subset_decoder.sv
// Byte-stream decoder for a register add and a move-immediate, each with an
// optional operand-size prefix. One byte is accepted on every cycle in which
// in_valid is high; there is no back-pressure. Records are registered and
// held; dec_done and dec_illegal are single-cycle strobes.
module isa_subset_decoder
    import isad_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int IMM_BYTES = 4,
    parameter int REG_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [BYTE_W-1:0]           in_byte,
    output logic                        dec_done,
    output logic                        dec_illegal,
    output logic [1:0]                  dec_op,
    output logic [REG_W-1:0]            dec_dst,
    output logic [REG_W-1:0]            dec_src,
    output logic [1:0]                  dec_size,
    output logic [BYTE_W*IMM_BYTES-1:0] dec_imm
);

    localparam int IMM_W  = BYTE_W * IMM_BYTES;
    localparam int LANE_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
    localparam int CNT_W  = $clog2(IMM_BYTES + 1);
    localparam int SHORT_BYTES = IMM_BYTES / 2;

    dec_state_e        state;
    byte_class_e       cls;
    logic              pfx;
    logic              dir_bit;
    logic              wid_bit;
    logic [REG_W-1:0]  movi_reg;
    logic [CNT_W-1:0]  left;
    logic [LANE_W-1:0] lane;
    logic [IMM_W-1:0]  imm_merged;
    logic              take_opc;
    logic              take_imm;
    logic [1:0]        mode_f;
    logic [REG_W-1:0]  reg_f;
    logic [REG_W-1:0]  rm_f;

    // Split the operand byte into its fields.
    assign mode_f = in_byte[7:6];
    assign reg_f  = in_byte[5:3];
    assign rm_f   = in_byte[2:0];

    // Qualify byte acceptance by the current parse position.
    assign take_opc = in_valid && (state == ST_OPC);
    assign take_imm = in_valid && (state == ST_IMM);

    isad_classify #(.BYTE_W(BYTE_W)) u_classify (
        .opc (in_byte),
        .cls (cls)
    );

    isad_imm_gather #(.BYTE_W(BYTE_W), .NBYTES(IMM_BYTES)) u_imm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (take_opc),
        .load   (take_imm),
        .lane   (lane),
        .din    (in_byte),
        .merged (imm_merged)
    );

    // Parse sequencer: tracks prefix, position and the decoded record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OPC;
            pfx         <= 1'b0;
            dir_bit     <= 1'b0;
            wid_bit     <= 1'b0;
            movi_reg    <= '0;
            left        <= '0;
            lane        <= '0;
            dec_done    <= 1'b0;
            dec_illegal <= 1'b0;
            dec_op      <= OP_NONE;
            dec_dst     <= '0;
            dec_src     <= '0;
            dec_size    <= SZ_8;
            dec_imm     <= '0;
        end else begin
            dec_done    <= 1'b0;
            dec_illegal <= 1'b0;
            if (in_valid) begin
                case (state)
                    ST_OPC: begin
                        case (cls)
                            CLS_PFX: pfx <= 1'b1;
                            CLS_ADD: begin
                                dir_bit <= in_byte[1];
                                wid_bit <= in_byte[0];
                                state   <= ST_MODRM;
                            end
                            CLS_MOVI: begin
                                movi_reg <= in_byte[2:0];
                                left     <= pfx ? CNT_W'(IMM_BYTES) : CNT_W'(SHORT_BYTES);
                                lane     <= '0;
                                state    <= ST_IMM;
                            end
                            default: begin
                                dec_illegal <= 1'b1;
                                pfx         <= 1'b0;
                            end
                        endcase
                    end
                    ST_MODRM: begin
                        state <= ST_OPC;
                        pfx   <= 1'b0;
                        if (mode_f != MODE_REG) begin
                            dec_illegal <= 1'b1;
                        end else begin
                            dec_done <= 1'b1;
                            dec_op   <= OP_ADD;
                            dec_dst  <= dir_bit ? reg_f : rm_f;
                            dec_src  <= dir_bit ? rm_f : reg_f;
                            dec_imm  <= '0;
                            dec_size <= !wid_bit ? SZ_8 : (pfx ? SZ_32 : SZ_16);
                        end
                    end
                    ST_IMM: begin
                        lane <= lane + LANE_W'(1);
                        left <= left - CNT_W'(1);
                        if (left == CNT_W'(1)) begin
                            dec_done <= 1'b1;
                            dec_op   <= OP_MOVI;
                            dec_dst  <= movi_reg;
                            dec_src  <= '0;
                            dec_imm  <= imm_merged;
                            dec_size <= pfx ? SZ_32 : SZ_16;
                            pfx      <= 1'b0;
                            state    <= ST_OPC;
                        end
                    end
                    default: state <= ST_OPC;
                endcase
            end
        end
    end

endmodule

// File: rtl/isad_checker.sv
// Port-level properties of the subset decoder, bound into every instance.
module isad_checker #(
    parameter int BYTE_W    = 8,
    parameter int IMM_BYTES = 4,
    parameter int REG_W     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [BYTE_W-1:0]           in_byte,
    input logic                        dec_done,
    input logic                        dec_illegal,
    input logic [1:0]                  dec_op,
    input logic [REG_W-1:0]            dec_dst,
    input logic [REG_W-1:0]            dec_src,
    input logic [1:0]                  dec_size,
    input logic [BYTE_W*IMM_BYTES-1:0] dec_imm
);

    localparam int IMM_W  = BYTE_W * IMM_BYTES;
    localparam int HALF_W = IMM_W / 2;

    logic [BYTE_W-1:0] unused_byte;
    assign unused_byte = in_byte;

    // Every instruction spans at least two bytes, so completions never touch.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_done && dec_illegal));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!dec_done && !dec_illegal));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dec_op) && $stable(dec_dst) && $stable(dec_src)
                       && $stable(dec_size) && $stable(dec_imm)));

    a_r9_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> ($stable(dec_op) && $stable(dec_dst) && $stable(dec_imm)));

    a_r5_movi_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_op == 2'd2) |-> (dec_size != 2'd0 && dec_src == '0));

    a_r6_short_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_op == 2'd2 && dec_size == 2'd1) |-> (dec_imm[IMM_W-1:HALF_W] == '0));

    a_r2_add_noimm: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_op == 2'd1) |-> (dec_imm == '0));

endmodule

bind isa_subset_decoder isad_checker #(
    .BYTE_W(BYTE_W), .IMM_BYTES(IMM_BYTES), .REG_W(REG_W)
) u_isad_checker (.*);

// File: tb/isa_subset_decoder_bench.sv
module isa_subset_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        dec_done;
    logic        dec_illegal;
    logic [1:0]  dec_op;
    logic [2:0]  dec_dst;
    logic [2:0]  dec_src;
    logic [1:0]  dec_size;
    logic [31:0] dec_imm;

    int n_checks = 0;
    int n_fail   = 0;

    // model of the held record (op,dst,src,size,imm)
    logic [41:0] m_rec = '0;

    logic [7:0] bq [0:7];
    int         bn;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_subset_decoder u_isa_subset_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .dec_done(dec_done), .dec_illegal(dec_illegal), .dec_op(dec_op),
        .dec_dst(dec_dst), .dec_src(dec_src), .dec_size(dec_size), .dec_imm(dec_imm)
    );

    function automatic logic [41:0] pack_rec(logic [1:0] op, logic [2:0] d,
                                             logic [2:0] s, logic [1:0] sz, logic [31:0] im);
        return {op, d, s, sz, im};
    endfunction

    function automatic logic [41:0] out_rec();
        return {dec_op, dec_dst, dec_src, dec_size, dec_imm};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b);
        bq[bn] = b;
        bn++;
    endtask

    // kind: 1 = expect completion with rec, 2 = expect rejection
    task automatic send_seq(int kind, logic [41:0] rec, bit gaps);
        for (int i = 0; i < bn; i++) begin
            int g;
            g = (gaps && ($urandom % 3 == 0)) ? int'($urandom % 3) + 1 : 0;
            for (int k = 0; k < g; k++) begin
                in_valid = 1'b0;
                in_byte  = 8'($urandom);
                @(negedge clk);
                chk("R11 idle strobes", {62'd0, dec_done, dec_illegal}, 64'd0);
            end
            in_valid = 1'b1;
            in_byte  = bq[i];
            @(negedge clk);
            in_valid = 1'b0;
            if (i < bn - 1) begin
                chk("R8 no strobe mid-instruction", {62'd0, dec_done, dec_illegal}, 64'd0);
            end else if (kind == 1) begin
                m_rec = rec;
                chk("R8 done strobe", {62'd0, dec_done, dec_illegal}, 64'd2);
                chk("R2-R6 record", {22'd0, out_rec()}, {22'd0, m_rec});
            end else begin
                chk("R9/R10 illegal strobe", {62'd0, dec_done, dec_illegal}, 64'd1);
                chk("R9/R10 record held", {22'd0, out_rec()}, {22'd0, m_rec});
            end
        end
        bn = 0;
    endtask

    task automatic rand_instr();
        int t, np;
        bit pf;
        logic d, w;
        logic [2:0] r, rm;
        logic [31:0] v;
        logic [7:0] ob;
        t  = int'($urandom % 4);
        np = int'($urandom % 3);
        pf = (np > 0);
        for (int i = 0; i < np; i++) push(8'h66);
        d = 1'($urandom); w = 1'($urandom);
        r = 3'($urandom); rm = 3'($urandom);
        case (t)
            0: begin
                push({6'b0, d, w});
                push({2'b11, r, rm});
                send_seq(1, pack_rec(2'd1, d ? r : rm, d ? rm : r,
                                     !w ? 2'd0 : (pf ? 2'd2 : 2'd1), 32'd0), 1'b1);
            end
            1: begin
                push({6'b0, d, w});
                push({2'($urandom % 3), r, rm});
                send_seq(2, '0, 1'b1);
            end
            2: begin
                v = $urandom;
                if (!pf) v[31:16] = 16'd0;
                push({5'b10111, r});
                for (int k = 0; k < (pf ? 4 : 2); k++) push(v[8*k +: 8]);
                send_seq(1, pack_rec(2'd2, r, 3'd0, pf ? 2'd2 : 2'd1, v), 1'b1);
            end
            default: begin
                do ob = 8'($urandom);
                while (ob == 8'h66 || ob[7:2] == 6'd0 || ob[7:3] == 5'b10111);
                push(ob);
                send_seq(2, '0, 1'b1);
            end
        endcase
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bn = 0;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {62'd0, dec_done, dec_illegal}, 64'd0);
        chk("R1 reset record", {22'd0, out_rec()}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: 03 C3 -> dst A(0), src B(3), 16-bit
        push(8'h03); push(8'hC3);
        send_seq(1, pack_rec(2'd1, 3'd0, 3'd3, 2'd1, 32'd0), 1'b0);
        // R3/R4: direction clear, byte width
        push(8'h00); push(8'hC3);
        send_seq(1, pack_rec(2'd1, 3'd3, 3'd0, 2'd0, 32'd0), 1'b0);
        // R4: prefixed word add -> 32 bits
        push(8'h66); push(8'h01); push(8'hD1);
        send_seq(1, pack_rec(2'd1, 3'd1, 3'd2, 2'd2, 32'd0), 1'b0);
        // R6: 66 B8 78 56 34 12
        push(8'h66); push(8'hB8); push(8'h78); push(8'h56); push(8'h34); push(8'h12);
        send_seq(1, pack_rec(2'd2, 3'd0, 3'd0, 2'd2, 32'h12345678), 1'b0);
        // R5: unprefixed move, 2 bytes
        push(8'hB9); push(8'h34); push(8'h12);
        send_seq(1, pack_rec(2'd2, 3'd1, 3'd0, 2'd1, 32'h00001234), 1'b0);
        // R9: mode 10 rejected
        push(8'h66); push(8'h03); push(8'h83);
        send_seq(2, '0, 1'b0);
        // R7: prefix dropped by rejection, next move is 16-bit
        push(8'hB8); push(8'hEF); push(8'hBE);
        send_seq(1, pack_rec(2'd2, 3'd0, 3'd0, 2'd1, 32'h0000BEEF), 1'b0);
        // R10/R7: prefix then unknown opcode, then plain add stays 16-bit
        push(8'h66); push(8'h90);
        send_seq(2, '0, 1'b0);
        push(8'h03); push(8'hFF);
        send_seq(1, pack_rec(2'd1, 3'd7, 3'd7, 2'd1, 32'd0), 1'b0);
        // R7: repeated prefixes act as one
        push(8'h66); push(8'h66); push(8'hBF);
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        send_seq(1, pack_rec(2'd2, 3'd7, 3'd0, 2'd2, 32'h04030201), 1'b0);

        for (int n = 0; n < 400; n++) rand_instr();

        // R8: record holds after completion with no further bytes
        repeat (3) @(negedge clk);
        chk("R8 record holds", {22'd0, out_rec()}, {22'd0, m_rec});

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule